// File: doc/BRIEF.md
# Stuffing-Gated Dual-Clock Byte FIFO

This block moves recovered transport-stream bytes from a decoder running on a fixed 27 MHz write clock into an application read clock domain. Each stored entry is ten bits wide. It holds the data byte, the decoder's word-error flag and the decoder's stuffing indicator. On every write-clock cycle that the decoder does not flag as stuffing, one entry is written. When the stuffing indicator is high, nothing is stored for that cycle. The application drains the queue on its own clock and watches the empty and full flags.

The queue runs only while its enable input is high and a 2-bit mode field holds the streaming code. The mode field takes the streaming code whenever the stream-select input is high at reset or goes high later. Software can overwrite the field through a write strobe. Both pointers are gray-coded, one bit wider than the address, and pass between the domains through two-flop synchronisers. A read-side reset request input exists, but it has no effect in this mode.

Top module: `streamFifo`

## Requirements
- R1: Each read returns, as one unit, the 8-bit byte on `rdData`, the word-error flag on `rdWordErr` and the stuffing bit on `rdSync` that were captured together at write time. Bit 9 of an entry is the stuffing bit, bit 8 is the word-error flag and bits 7:0 are the data.
- R2: While active, on every `wrClk` rising edge where `wrSync` is low and `full` is low, one entry is stored from `wrData`, `wrWordErr` and `wrSync`.
- R3: On a `wrClk` edge where `wrSync` is high, no entry is stored and the write pointer does not move.
- R4: On a `rdClk` rising edge where `rdEn` is high and `empty` is low, the oldest entry is loaded onto the read outputs. Entries leave in the order they were written.
- R5: The queue is active only when `fifoEn` is 1 and `modeQ` equals 2'b01. While it is inactive, both pointers are held at zero, `empty` reads 1, `full` reads 0 and write cycles store nothing.
- R6: At reset, `modeQ` loads 2'b01 if `asiSel` is high and 2'b00 otherwise. A rising edge of `asiSel` sets `modeQ` to 2'b01. Otherwise, `modeWe` loads `modeWdata` into `modeQ` on `wrClk`.
- R7: `rdRstReq` has no effect. Stored entries, pointers and read outputs behave as if it were low.
- R8: `empty` is high when the read pointer has caught up with the synchronised write pointer. A read request while `empty` is high leaves the pointer and the read outputs unchanged.
- R9: `full` is high when DEPTH entries are held. A write cycle while `full` is high stores nothing, so the first DEPTH entries are kept.
- R10: Each pointer's gray code changes by at most one bit per clock of its own domain while the queue is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | 27 MHz decoder (write) clock |
| rdClk | input | 1 | Application read clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| fifoEn | input | 1 | Queue enable |
| asiSel | input | 1 | Stream-select input; sets the mode field default |
| modeWe | input | 1 | Mode field write strobe (wrClk) |
| modeWdata | input | 2 | Value loaded into the mode field |
| modeQ | output | 2 | Current mode field |
| wrData | input | 8 | Recovered byte from the decoder |
| wrSync | input | 1 | Stuffing indicator; high suppresses the write |
| wrWordErr | input | 1 | Decoder word-error flag |
| rdEn | input | 1 | Read request (rdClk) |
| rdRstReq | input | 1 | Read-side reset request, ignored in this mode |
| rdData | output | 8 | Byte of the last entry read |
| rdSync | output | 1 | Stuffing bit of the last entry read |
| rdWordErr | output | 1 | Word-error flag of the last entry read |
| empty | output | 1 | No entry available (rdClk domain) |
| full | output | 1 | DEPTH entries held (wrClk domain) |

## Verification
On every cycle, assertions check that the pointers do not move when full, when empty or during stuffing. They also check that the gray codes step by one bit, that the pointers stay at zero while the queue is inactive, that the mode field takes the streaming code on a select edge, and that the read-reset request cannot move the read pointer. Only the bench scenarios can show what data actually arrives. These scenarios cover byte, error and stuffing patterns coming out in order, stuffing cycles missing from the stream, the first sixteen entries surviving an overfill, and writes made while inactive being lost. They also cover the mode field's reset default following the select input, and the read outputs holding after a read made while empty.

// File: rtl/fifoPkg.sv
package fifoPkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] MODE_STREAM = 2'b01;

  typedef struct packed {
    logic              sync;
    logic              wordErr;
    logic [BYTE_W-1:0] data;
  } entry_t;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } strobe_t;
endpackage

// File: rtl/syncCell.sv
module syncCell #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fifoCtrl.sv
module fifoCtrl
  import fifoPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          fifoEn,
  input  logic          asiSel,
  input  logic          modeWe,
  input  logic [1:0]    modeWdata,
  input  logic          wrSync,
  input  logic          rdEn,
  input  logic          rdRstReq,
  output strobe_t       strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [1:0]    modeQ,
  output logic          empty,
  output logic          full
);
  localparam int PW = AW + 1;

  // ---------------- mode field (write domain) ----------------
  logic [1:0] modeR;
  logic       asiQ;
  logic       activeWr;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      modeR <= asiSel ? MODE_STREAM : 2'b00;
      asiQ  <= asiSel;
    end else begin
      asiQ <= asiSel;
      if (asiSel && !asiQ) modeR <= MODE_STREAM;
      else if (modeWe)     modeR <= modeWdata;
    end
  end

  assign activeWr = fifoEn && (modeR == MODE_STREAM);
  assign modeQ    = modeR;

  p_mode_default_r6: assert property (@(posedge wrClk) disable iff (!rstN)
    (asiSel && !asiQ) |=> (modeR == MODE_STREAM));

  // ---------------- pointers ----------------
  logic [PW-1:0] wrBin, wrBinNext, wrGray, rdGrayW;
  logic [PW-1:0] rdBin, rdBinNext, rdGray, wrGrayR;
  logic          activeRd;
  logic          wrGo, rdGo, fullW, emptyR;

  syncCell #(.W(PW)) i_rdToWr (.clk(wrClk), .rstN(rstN), .d(rdGray),   .q(rdGrayW));
  syncCell #(.W(PW)) i_wrToRd (.clk(rdClk), .rstN(rstN), .d(wrGray),   .q(wrGrayR));
  syncCell #(.W(1))  i_actSync(.clk(rdClk), .rstN(rstN), .d(activeWr), .q(activeRd));

  // write domain
  assign fullW     = activeWr &&
                     (wrGray == {~rdGrayW[PW-1:PW-2], rdGrayW[PW-3:0]});
  assign wrGo      = activeWr && !wrSync && !fullW;
  assign wrBinNext = !activeWr ? '0 : (wrGo ? wrBin + 1'b1 : wrBin);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  // read domain
  assign emptyR    = !activeRd || (rdGray == wrGrayR);
  assign rdGo      = activeRd && rdEn && !emptyR;
  assign rdBinNext = !activeRd ? '0 : (rdGo ? rdBin + 1'b1 : rdBin);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
    end
  end

  assign strb.wrEn = wrGo;
  assign strb.rdEn = rdGo;
  assign wrAddr    = wrBin[AW-1:0];
  assign rdAddr    = rdBin[AW-1:0];
  assign empty     = emptyR;
  assign full      = fullW;

  // ---------------- pointer checks ----------------
  p_no_overflow_r9: assert property (@(posedge wrClk) disable iff (!rstN || !activeWr)
    fullW |=> $stable(wrBin));
  p_stuff_hold_r3: assert property (@(posedge wrClk) disable iff (!rstN || !activeWr)
    wrSync |=> $stable(wrBin));
  p_no_underflow_r8: assert property (@(posedge rdClk) disable iff (!rstN || !activeRd)
    emptyR |=> $stable(rdBin));
  p_rdrst_ignored_r7: assert property (@(posedge rdClk) disable iff (!rstN || !activeRd)
    (rdRstReq && !rdEn) |=> $stable(rdBin));
  p_idle_wr_r5: assert property (@(posedge wrClk) disable iff (!rstN)
    !activeWr |=> (wrBin == '0));
  p_idle_rd_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    !activeRd |=> (rdBin == '0));
  p_wr_gray_step_r10: assert property (@(posedge wrClk) disable iff (!rstN || !activeWr)
    $countones(wrGray ^ $past(wrGray)) <= 1);
  p_rd_gray_step_r10: assert property (@(posedge rdClk) disable iff (!rstN || !activeRd)
    $countones(rdGray ^ $past(rdGray)) <= 1);
endmodule

// File: rtl/fifoData.sv
module fifoData
  import fifoPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  entry_t        wrEntry,
  output entry_t        rdEntry
);
  entry_t store [DEPTH];
  entry_t outQ;

  always_ff @(posedge wrClk) begin
    if (strb.wrEn) store[wrAddr] <= wrEntry;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          outQ <= '0;
    else if (strb.rdEn) outQ <= store[rdAddr];
  end

  assign rdEntry = outQ;

  p_rd_hold_r8: assert property (@(posedge rdClk) disable iff (!rstN)
    !strb.rdEn |=> $stable(outQ));
endmodule

// File: rtl/streamFifo.sv
module streamFifo
  import fifoPkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        rstN,
  input  logic        fifoEn,
  input  logic        asiSel,
  input  logic        modeWe,
  input  logic [1:0]  modeWdata,
  output logic [1:0]  modeQ,
  input  logic [7:0]  wrData,
  input  logic        wrSync,
  input  logic        wrWordErr,
  input  logic        rdEn,
  input  logic        rdRstReq,
  output logic [7:0]  rdData,
  output logic        rdSync,
  output logic        rdWordErr,
  output logic        empty,
  output logic        full
);
  localparam int AW = $clog2(DEPTH);

  strobe_t       strb;
  logic [AW-1:0] wrAddr, rdAddr;
  entry_t        wrEntry, rdEntry;

  assign wrEntry = '{sync: wrSync, wordErr: wrWordErr, data: wrData};

  fifoCtrl #(.DEPTH(DEPTH), .AW(AW)) i_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .fifoEn(fifoEn), .asiSel(asiSel), .modeWe(modeWe), .modeWdata(modeWdata),
    .wrSync(wrSync), .rdEn(rdEn), .rdRstReq(rdRstReq),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .modeQ(modeQ), .empty(empty), .full(full)
  );

  fifoData #(.DEPTH(DEPTH), .AW(AW)) i_data (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrEntry(wrEntry), .rdEntry(rdEntry)
  );

  assign rdData    = rdEntry.data;
  assign rdSync    = rdEntry.sync;
  assign rdWordErr = rdEntry.wordErr;
endmodule

// File: tb/test_streamFifo.sv
module test_streamFifo;
  logic       wrClk = 0, rdClk = 0, rstN = 0;
  logic       fifoEn = 0, asiSel = 1, modeWe = 0;
  logic [1:0] modeWdata = 0, modeQ;
  logic [7:0] wrData = 0, rdData;
  logic       wrSync = 1, wrWordErr = 0, rdEn = 0, rdRstReq = 0;
  logic       rdSync, rdWordErr, empty, full;

  always #4  rdClk = ~rdClk;   // 125 MHz
  always #18 wrClk = ~wrClk;   // about 27 MHz

  streamFifo i_streamFifo (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fifoEn(fifoEn), .asiSel(asiSel),
    .modeWe(modeWe), .modeWdata(modeWdata), .modeQ(modeQ),
    .wrData(wrData), .wrSync(wrSync), .wrWordErr(wrWordErr),
    .rdEn(rdEn), .rdRstReq(rdRstReq), .rdData(rdData), .rdSync(rdSync),
    .rdWordErr(rdWordErr), .empty(empty), .full(full)
  );

  // {sync, wordErr, data}
  localparam logic [9:0] VEC [12] = '{
    10'h0A5, 10'h13C, 10'h2FF, 10'h000, 10'h1FF, 10'h3AA,
    10'h255, 10'h081, 10'h17E, 10'h2BC, 10'h0C3, 10'h112 };

  int total = 0, fails = 0;
  bit done = 0;
  logic [9:0] expQ [64];
  int nExp;
  logic [9:0] got;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wrClk);
  endtask

  task automatic readOne(output logic [9:0] v);
    @(negedge rdClk) rdEn = 1;
    @(negedge rdClk) rdEn = 0;
    v = {rdSync, rdWordErr, rdData};
  endtask

  task automatic writeCycle(input logic [9:0] e);
    @(negedge wrClk);
    {wrSync, wrWordErr, wrData} = e;
  endtask

  task automatic stopWrite();
    @(negedge wrClk) wrSync = 1;
  endtask

  initial begin
    #100;
    @(negedge wrClk) rstN = 1;
    settle();
    chk("R6 reset default with select high", modeQ, 2'b01);
    @(negedge rdClk);
    chk("R5 empty while disabled", empty, 1);
    chk("R5 full while disabled", full, 0);

    // writes while disabled are lost
    for (int i = 0; i < 5; i++) writeCycle({2'b00, 8'(8'h40 + i)});
    stopWrite();
    fifoEn = 1;
    settle();
    @(negedge rdClk);
    chk("R5 disabled writes discarded", empty, 1);

    // table walk
    nExp = 0;
    for (int i = 0; i < 12; i++) begin
      writeCycle(VEC[i]);
      if (!VEC[i][9]) begin expQ[nExp] = VEC[i]; nExp++; end
    end
    stopWrite();
    settle();
    @(negedge rdClk);
    chk("R2 data present after writes", empty, 0);
    for (int i = 0; i < nExp; i++) begin
      if (i == 3) begin  // R7: read-reset request pulse mid-stream
        @(negedge rdClk) rdRstReq = 1;
        repeat (3) @(negedge rdClk);
        rdRstReq = 0;
        chk("R7 request leaves outputs", {rdSync, rdWordErr, rdData}, expQ[2]);
      end
      readOne(got);
      chk("R1 R3 R4 entry order and fields", got, expQ[i]);
    end
    @(negedge rdClk);
    chk("R3 stuffing cycles not stored, empty after drain", empty, 1);

    // read while empty
    readOne(got);
    chk("R8 read while empty holds outputs", got, expQ[nExp-1]);
    chk("R8 still empty", empty, 1);

    // overfill
    for (int i = 0; i < 20; i++) writeCycle({2'b00, 8'(i)});
    stopWrite();
    @(negedge wrClk);
    chk("R9 full after depth writes", full, 1);
    settle();
    for (int i = 0; i < 16; i++) begin
      readOne(got);
      chk("R9 first entries kept", got, {2'b00, 8'(i)});
    end
    @(negedge rdClk);
    chk("R9 R8 empty after depth reads", empty, 1);
    settle();
    chk("R9 full cleared", full, 0);

    // mode field switched away
    for (int i = 0; i < 3; i++) writeCycle({2'b01, 8'(8'h90 + i)});
    stopWrite();
    @(negedge wrClk) begin modeWe = 1; modeWdata = 2'b10; end
    @(negedge wrClk) modeWe = 0;
    settle();
    chk("R6 software write", modeQ, 2'b10);
    @(negedge rdClk);
    chk("R5 empty when mode off", empty, 1);
    chk("R5 full low when mode off", full, 0);
    for (int i = 0; i < 4; i++) writeCycle({2'b00, 8'h33});
    stopWrite();
    @(negedge wrClk) begin modeWe = 1; modeWdata = 2'b01; end
    @(negedge wrClk) modeWe = 0;
    settle();
    @(negedge rdClk);
    chk("R5 queue cleared and writes lost", empty, 1);
    writeCycle({2'b01, 8'h77});
    stopWrite();
    settle();
    readOne(got);
    chk("R5 pointers restart at zero", got, {2'b01, 8'h77});

    // mode default with select low
    asiSel = 0;
    @(negedge wrClk) rstN = 0;
    @(negedge wrClk) rstN = 1;
    settle();
    chk("R6 reset default with select low", modeQ, 2'b00);
    @(negedge wrClk) asiSel = 1;
    settle();
    chk("R6 select edge sets streaming code", modeQ, 2'b01);
    @(negedge wrClk) begin modeWe = 1; modeWdata = 2'b11; end
    @(negedge wrClk) modeWe = 0;
    settle();
    chk("R6 software overwrite after default", modeQ, 2'b11);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule